// File: doc/BRIEF.md
# Half-Duplex Smart-Card Serial Transceiver

This block is a character transceiver for a smart-card link in which one open-drain wire carries traffic both ways. Each character is a low start bit, eight data bits least significant first, an even parity bit and a high stop bit. The block only ever pulls the wire low or releases it. It watches the wire through a synchronizer. This lets it receive, and it also lets it notice when the far end answers a character it just sent.

The error handshake works in both directions. When the receiver gets a character whose parity is wrong, it holds the wire low for the whole stop-bit period of that character. When the transmitter finishes a character, it reports the wire level it sampled in the middle of the stop bit, so software can tell whether the far end refused the character.

Software writes a byte into a one-entry buffer, reads received bytes from a holding register, and sets the bit rate with a divisor. Interrupt requests are single-cycle pulses.

Top module: `sc_uart`

## Requirements
- R1: One bit lasts exactly 16*(baud_div+1) clock cycles. baud_div is held stable while a character is in flight.
- R2: A transmitted character, seen on line_pull_low (1 = pull the wire low, 0 = release), is: start bit (pull), data bits 0 to 7 (pull when the bit is 0), even parity bit (the XOR of the data bits, pull when it is 0), and stop bit (release).
- R3: After reset, and whenever neither direction is busy, line_pull_low is 0. After reset, tx_buf_empty and tx_empty are 1, and rx_ready, tx_nack_seen, tx_irq and rx_irq are 0.
- R4: A tx_wr taken while the buffer is empty fills the buffer, so tx_buf_empty falls after that edge. If the shifter is free, the byte moves to it at the next edge and tx_buf_empty rises again. tx_empty is 1 only when both the buffer and the shifter are empty. A tx_wr while the buffer is full is dropped.
- R5: tx_irq is a one-cycle pulse in the cycle right after the stop bit of each character ends. Moving a byte from the buffer to the shifter raises no pulse.
- R6: tx_nack_seen takes the inverse of the wire level sampled at the middle of the stop bit, and is updated when the character ends. It clears at the edge where the next character starts.
- R7: After a complete received character, rx_byte holds the data, rx_ready is set and rx_irq pulses for one cycle. rx_rd clears rx_ready.
- R8: On a received parity mismatch, the block pulls the wire low for the stop-bit period and sets rx_parity_err with that character. It never pulls the wire during the data bits of a received character.
- R9: Reception begins only on a high-to-low transition of the synchronized wire. A start bit that is high again at its midpoint (sample 8 of 16) is discarded, and no character is reported.
- R10: The receiver ignores the wire while the transmitter is sending, so the block's own characters are never received. A byte written during a reception waits in the buffer until the reception ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Bit-rate divisor n; a bit lasts 16*(n+1) cycles |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_byte | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read acknowledge; clears rx_ready |
| line_in | input | 1 | Level of the shared wire |
| line_pull_low | output | 1 | Open-drain enable: 1 pulls the wire low |
| tx_buf_empty | output | 1 | Transmit buffer is free |
| tx_empty | output | 1 | Buffer and shifter are both empty |
| tx_nack_seen | output | 1 | Far end held the stop bit low on the last sent character |
| rx_byte | output | 8 | Last received byte |
| rx_ready | output | 1 | A received byte is waiting |
| rx_parity_err | output | 1 | The last received character had bad parity |
| tx_irq | output | 1 | Pulse: a character has finished transmitting |
| rx_irq | output | 1 | Pulse: a character has been received |

## Verification
The assertions check, on every cycle:
- the transmitter and receiver are never busy at once;
- the wire is released whenever both directions are idle;
- a character never starts while the refusal flag is still set or while the buffer still counts as full;
- both interrupt pulses last exactly one cycle, and each lines up with the state it announces.

Only the bench scenarios can show the rest:
- the exact bit waveform and its timing at two divisor values;
- whether the parity bit is correct;
- a refusal sampled during the stop bit;
- the error pull-down on a bad received character;
- that a glitched start bit is rejected;
- that a byte written during a reception is held back.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
  localparam int unsigned OSR       = 16;
  localparam int unsigned SUB_W     = $clog2(OSR);
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned FRAME_LEN = DATA_W + 3;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int unsigned PAR_IDX   = FRAME_LEN - 2;
  localparam int unsigned STOP_IDX  = FRAME_LEN - 1;
endpackage

// File: rtl/sc_uart_tick.sv
module sc_uart_tick
  import sc_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mid,
  output logic             bend
);
  logic [DIV_W-1:0] pre_q, pre_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             wrap;

  assign wrap = (pre_q == div);

  always_comb begin
    pre_d = pre_q;
    sub_d = sub_q;
    if (!run) begin
      pre_d = '0;
      sub_d = '0;
    end else if (wrap) begin
      pre_d = '0;
      sub_d = sub_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= pre_d;
      sub_q <= sub_d;
    end
  end

  assign mid  = run && wrap && (sub_q == SUB_W'(OSR/2 - 1));
  assign bend = run && wrap && (sub_q == SUB_W'(OSR - 1));
endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx
  import sc_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              line_s,
  input  logic              rx_busy,
  input  logic              mid,
  input  logic              bend,
  output logic              busy,
  output logic              load,
  output logic              drive_low,
  output logic              buf_empty,
  output logic              irq,
  output logic              nack_seen
);
  logic [DATA_W-1:0]    buf_q, buf_d;
  logic                 full_q, full_d;
  logic                 busy_q, busy_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 stop_q, stop_d;
  logic                 nack_q, nack_d;
  logic                 irq_q, irq_d;
  logic                 last;

  assign load = full_q && !busy_q && !rx_busy;
  assign last = busy_q && bend && (cnt_q == CNT_W'(STOP_IDX));

  always_comb begin
    buf_d  = buf_q;
    full_d = full_q;
    busy_d = busy_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    stop_d = stop_q;
    nack_d = nack_q;
    irq_d  = 1'b0;
    if (wr && !full_q) begin
      buf_d  = wdata;
      full_d = 1'b1;
    end
    if (load) begin
      full_d = 1'b0;
      busy_d = 1'b1;
      sh_d   = {1'b1, ^buf_q, buf_q, 1'b0};
      cnt_d  = '0;
      stop_d = 1'b1;
      nack_d = 1'b0;
    end else if (busy_q) begin
      if (mid && (cnt_q == CNT_W'(STOP_IDX))) stop_d = line_s;
      if (bend) begin
        sh_d  = {1'b1, sh_q[FRAME_LEN-1:1]};
        cnt_d = cnt_q + 1'b1;
      end
      if (last) begin
        busy_d = 1'b0;
        irq_d  = 1'b1;
        nack_d = !stop_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      stop_q <= 1'b1;
      nack_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      stop_q <= stop_d;
      nack_q <= nack_d;
      irq_q  <= irq_d;
    end
  end

  assign busy      = busy_q;
  assign drive_low = busy_q && !sh_q[0];
  assign buf_empty = !full_q;
  assign irq       = irq_q;
  assign nack_seen = nack_q;
endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx
  import sc_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  input  logic              tx_busy,
  input  logic              tx_load,
  input  logic              mid,
  input  logic              bend,
  input  logic              rd,
  output logic              busy,
  output logic              drive_low,
  output logic [DATA_W-1:0] data,
  output logic              ready,
  output logic              perr,
  output logic              irq
);
  logic              prev_q, prev_d;
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              nack_q, nack_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ready_q, ready_d;
  logic              perr_q, perr_d;
  logic              irq_q, irq_d;
  logic              start;

  assign start = !busy_q && !tx_busy && !tx_load && prev_q && !line_s;

  always_comb begin
    prev_d  = line_s;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    par_d   = par_q;
    nack_d  = nack_q;
    data_d  = data_q;
    ready_d = ready_q;
    perr_d  = perr_q;
    irq_d   = 1'b0;
    if (rd) ready_d = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      par_d  = 1'b0;
    end else if (busy_q) begin
      if (mid) begin
        if (cnt_q == '0) begin
          if (line_s) busy_d = 1'b0;
        end else if (cnt_q <= CNT_W'(DATA_W)) begin
          sh_d  = {line_s, sh_q[DATA_W-1:1]};
          par_d = par_q ^ line_s;
        end else if (cnt_q == CNT_W'(PAR_IDX)) begin
          par_d = par_q ^ line_s;
        end
      end
      if (bend) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(PAR_IDX)) nack_d = par_q;
        if (cnt_q == CNT_W'(STOP_IDX)) begin
          busy_d  = 1'b0;
          nack_d  = 1'b0;
          data_d  = sh_q;
          ready_d = 1'b1;
          perr_d  = par_q;
          irq_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      nack_q  <= 1'b0;
      data_q  <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      nack_q  <= nack_d;
      data_q  <= data_d;
      ready_q <= ready_d;
      perr_q  <= perr_d;
      irq_q   <= irq_d;
    end
  end

  assign busy      = busy_q;
  assign drive_low = nack_q;
  assign data      = data_q;
  assign ready     = ready_q;
  assign perr      = perr_q;
  assign irq       = irq_q;
endmodule

// File: rtl/sc_uart.sv
module sc_uart
  import sc_uart_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rx_rd,
  input  logic              line_in,
  output logic              line_pull_low,
  output logic              tx_buf_empty,
  output logic              tx_empty,
  output logic              tx_nack_seen,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              rx_parity_err,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic [1:0]             rst_pipe;
  logic                   rst_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic                   tx_busy, tx_load, tx_drv, tx_mid, tx_bend;
  logic                   rx_busy, rx_drv, rx_mid, rx_bend;

  // Reset asserts at once and is released two edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_q) begin
        if (!rst_q) sync_q[s] <= 1'b1;
        else if (s == 0) sync_q[s] <= line_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign line_s = sync_q[SYNC_STAGES-1];

  sc_uart_tick #(.DIV_W(DIV_W)) u_tx_tick (
    .clk(clk), .rst_n(rst_q), .run(tx_busy), .div(baud_div),
    .mid(tx_mid), .bend(tx_bend)
  );

  sc_uart_tick #(.DIV_W(DIV_W)) u_rx_tick (
    .clk(clk), .rst_n(rst_q), .run(rx_busy), .div(baud_div),
    .mid(rx_mid), .bend(rx_bend)
  );

  sc_uart_tx u_tx (
    .clk(clk), .rst_n(rst_q), .wr(tx_wr), .wdata(tx_byte), .line_s(line_s),
    .rx_busy(rx_busy), .mid(tx_mid), .bend(tx_bend), .busy(tx_busy),
    .load(tx_load), .drive_low(tx_drv), .buf_empty(tx_buf_empty),
    .irq(tx_irq), .nack_seen(tx_nack_seen)
  );

  sc_uart_rx u_rx (
    .clk(clk), .rst_n(rst_q), .line_s(line_s), .tx_busy(tx_busy),
    .tx_load(tx_load), .mid(rx_mid), .bend(rx_bend), .rd(rx_rd),
    .busy(rx_busy), .drive_low(rx_drv), .data(rx_byte), .ready(rx_ready),
    .perr(rx_parity_err), .irq(rx_irq)
  );

  assign line_pull_low = tx_drv | rx_drv;
  assign tx_empty      = tx_buf_empty && !tx_busy;
endmodule

// File: rtl/sc_uart_chk.sv
module sc_uart_chk (
  input logic clk,
  input logic rst_q,
  input logic tx_busy,
  input logic rx_busy,
  input logic tx_irq,
  input logic rx_irq,
  input logic tx_buf_empty,
  input logic tx_nack_seen,
  input logic rx_ready,
  input logic line_pull_low
);
  p_half_duplex_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !(tx_busy && rx_busy));

  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (!tx_busy && !rx_busy) |-> !line_pull_low);

  p_tx_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_q)
    tx_irq |=> !tx_irq);

  p_tx_irq_at_end_r5: assert property (@(posedge clk) disable iff (!rst_q)
    tx_irq |-> ($fell(tx_busy) || (!tx_busy && !$past(tx_irq))));

  p_load_frees_buf_r4: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(tx_busy) |-> tx_buf_empty);

  p_nack_clear_r6: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(tx_busy) |-> !tx_nack_seen);

  p_rx_irq_ready_r7: assert property (@(posedge clk) disable iff (!rst_q)
    rx_irq |-> rx_ready);

  p_rx_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_q)
    rx_irq |=> !rx_irq);
endmodule

bind sc_uart sc_uart_chk u_chk (
  .clk(clk), .rst_q(rst_q), .tx_busy(tx_busy), .rx_busy(rx_busy),
  .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_buf_empty(tx_buf_empty),
  .tx_nack_seen(tx_nack_seen), .rx_ready(rx_ready),
  .line_pull_low(line_pull_low)
);

// File: tb/sc_uart_tb_top.sv
module sc_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_byte = 8'd0;
  logic       rx_rd = 1'b0;
  logic       card_pull = 1'b0;
  logic       line_in;
  logic       line_pull_low, tx_buf_empty, tx_empty, tx_nack_seen;
  logic [7:0] rx_byte;
  logic       rx_ready, rx_parity_err, tx_irq, rx_irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  // Open-drain wire: low when either side pulls.
  assign line_in = ~(line_pull_low | card_pull);

  sc_uart dut_i (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tx_wr(tx_wr),
    .tx_byte(tx_byte), .rx_rd(rx_rd), .line_in(line_in),
    .line_pull_low(line_pull_low), .tx_buf_empty(tx_buf_empty),
    .tx_empty(tx_empty), .tx_nack_seen(tx_nack_seen), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .rx_parity_err(rx_parity_err), .tx_irq(tx_irq),
    .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Send one byte (optionally a second, written at m=20) and compare the
  // wire drive against the expected waveform on every cycle.
  task automatic tx_run(input logic [7:0] a, input bit nack, input bit two,
                        input logic [7:0] b, input int n);
    int T;
    int total;
    logic [10:0] fa;
    logic [10:0] fb;
    T = 16 * (n + 1);
    fa = {1'b1, ^a, a, 1'b0};
    fb = {1'b1, ^b, b, 1'b0};
    total = two ? 22*T + 1 : 11*T;
    @(negedge clk); tx_wr = 1'b1; tx_byte = a;
    @(negedge clk); tx_wr = 1'b0;
    chk("R4", "buffer full after write", tx_buf_empty, 0);
    chk("R4", "not empty after write", tx_empty, 0);
    @(negedge clk);
    chk("R4", "buffer empty after move to shifter", tx_buf_empty, 1);
    chk("R6", "refusal flag clear at start", tx_nack_seen, 0);
    for (int m = 0; m <= total; m++) begin
      int k;
      int bitn;
      logic [10:0] f;
      logic exp_pull;
      if (m < 11*T) begin k = m; f = fa; end
      else if (two && m >= 11*T + 1) begin k = m - 11*T - 1; f = fb; end
      else begin k = -1; f = '1; end
      bitn = (k >= 0) ? k / T : 11;
      exp_pull = (k >= 0 && bitn < 10) ? !f[bitn] : 1'b0;
      chk("R2", "wire drive (R1 bit time)", line_pull_low, exp_pull);
      chk("R5", "tx irq", tx_irq, (m == 11*T) || (two && m == 22*T + 1));
      card_pull = nack && (m >= 10*T) && (m < 11*T);
      if (m == 11*T) begin
        chk("R6", "refusal flag at end", tx_nack_seen, nack);
        chk("R4", "tx_empty at end", tx_empty, !two);
      end
      if (two && m == 11*T + 1) chk("R6", "flag cleared by next start", tx_nack_seen, 0);
      if (two && m == 20) begin tx_wr = 1'b1; tx_byte = b; end
      if (two && m == 21) begin
        tx_wr = 1'b0;
        chk("R4", "buffer full while shifting", tx_buf_empty, 0);
        chk("R4", "tx_empty low with buffer full", tx_empty, 0);
      end
      if (m < total) @(negedge clk);
    end
    card_pull = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4", "tx_empty after last frame", tx_empty, 1);
  endtask

  // Act as the far end sending one character; optionally write a byte at m=wr_at.
  task automatic rx_run(input logic [7:0] d, input bit bad, input int n, input int wr_at);
    int T;
    int pulses;
    int seen;
    logic [10:0] f;
    T = 16 * (n + 1);
    f = {1'b1, (^d) ^ bad, d, 1'b0};
    @(negedge clk);
    for (int m = 0; m < 11*T; m++) begin
      card_pull = !f[m / T];
      if (m == 5*T) chk("R8", "no pull during data bits", line_pull_low, 0);
      if (m == 10*T + T/2) chk("R8", "stop-bit error pull", line_pull_low, bad);
      if (wr_at >= 0 && m == wr_at) begin tx_wr = 1'b1; tx_byte = 8'h5A; end
      if (wr_at >= 0 && m == wr_at + 1) tx_wr = 1'b0;
      if (wr_at >= 0 && m == wr_at + 3) chk("R10", "write held during reception", tx_buf_empty, 0);
      @(negedge clk);
    end
    card_pull = 1'b0;
    pulses = 0;
    for (int i = 0; i < 2*T + 8; i++) begin
      if (rx_irq) pulses++;
      @(negedge clk);
    end
    chk("R7", "rx irq pulses", pulses, 1);
    chk("R7", "rx ready", rx_ready, 1);
    chk("R7", "rx byte", rx_byte, d);
    chk("R8", "rx parity flag", rx_parity_err, bad);
    if (wr_at < 0) begin
      chk("R8", "wire released after stop", line_pull_low, 0);
    end else begin
      seen = 0;
      for (int i = 0; i < 13*T; i++) begin
        if (tx_irq) seen = 1;
        @(negedge clk);
      end
      chk("R10", "held byte sent after reception", seen, 1);
    end
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    chk("R7", "rx_rd clears ready", rx_ready, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3", "reset wire released", line_pull_low, 0);
    chk("R3", "reset buffer empty", tx_buf_empty, 1);
    chk("R3", "reset tx empty", tx_empty, 1);
    chk("R3", "reset rx ready", rx_ready, 0);
    chk("R3", "reset refusal flag", tx_nack_seen, 0);
    chk("R3", "reset irqs", {tx_irq, rx_irq}, 0);

    baud_div = 8'd0;
    tx_run(8'hA5, 1'b0, 1'b0, 8'h00, 0);
    chk("R10", "own frame not received", rx_ready, 0);
    tx_run(8'h3C, 1'b1, 1'b1, 8'hC3, 0);
    chk("R10", "own frames not received", rx_ready, 0);

    rx_run(8'h3C, 1'b0, 0, -1);
    rx_run(8'hA7, 1'b1, 0, -1);

    // A short low glitch is not a start bit.
    begin
      int pulses;
      pulses = 0;
      card_pull = 1'b1;
      repeat (4) @(negedge clk);
      card_pull = 1'b0;
      for (int i = 0; i < 12*16; i++) begin
        if (rx_irq) pulses++;
        @(negedge clk);
      end
      chk("R9", "glitch gives no character", pulses, 0);
      chk("R9", "glitch leaves ready clear", rx_ready, 0);
    end
    rx_run(8'h81, 1'b0, 0, 3*16);

    baud_div = 8'd2;
    repeat (4) @(negedge clk);
    tx_run(8'h96, 1'b1, 1'b0, 8'h00, 2);
    rx_run(8'h69, 1'b0, 2, -1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule